// File: doc/BRIEF.md
# Programmable Deglitch Strobe Generator

This block drives a deglitch strobe that is locked to the output sample period of a converter. Each sample period is cut into 32 equal intervals, numbered 0 to 31 by a 5-bit index. A pulse on `period_start` marks the first interval of a period, and each `interval_tick` moves the block on to the next interval. Two 5-bit selects choose where the strobe goes high and where it goes low. Each edge falls at the start of its chosen interval.

When the rise index is larger than the fall index, the high window runs past the end of one period into the next. If the two indices are equal, no window is produced. When the stand-alone input is held high, both selects are replaced by fixed defaults: rise at interval 31 and fall at interval 15. All selects are captured only at a period start. A change in the middle of a period therefore never cuts a pulse short. The interval tick is produced elsewhere and is an input here.

Top module: `dg_strobe_gen`

## Requirements
- R1: After reset is released, `strobe` is 0 and stays 0, even with interval ticks, until the first `period_start` pulse.
- R2: A clock with `period_start`=1 puts the interval index at 0, even when `interval_tick` is 1 in the same clock. A clock with only `interval_tick`=1 adds one to the index.
- R3: `strobe` is 1 from the clock edge on which the index becomes the captured rise index.
- R4: `strobe` is 0 from the clock edge on which the index becomes the captured fall index.
- R5: When rise > fall, `strobe` is 1 for indices ≥ rise or < fall. The window therefore wraps across the period boundary.
- R6: When rise equals fall, `strobe` stays 0 for the whole period.
- R7: `rise_sel`, `fall_sel` and `standalone` are captured only on a clock with `period_start`=1. Changes at any other time do not affect `strobe` until the next period start.
- R8: With `standalone`=1 captured at a period start, the rise index is 31 and the fall index is 15, whatever `rise_sel` and `fall_sel` hold. `strobe` is then 1 for index 31 and for indices 0 to 14.
- R9: `strobe` changes only on a clock where `period_start` or `interval_tick` is 1.
- R10: Without a period start, the index goes from 31 to 0 on the next tick and the window repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_start | input | 1 | One-clock pulse at the start of an output sample period |
| interval_tick | input | 1 | One-clock pulse that advances to the next interval |
| rise_sel | input | 5 | Index of the interval at whose start the strobe rises |
| fall_sel | input | 5 | Index of the interval at whose start the strobe falls |
| standalone | input | 1 | 1 = use fixed edges 31 and 15 instead of the selects |
| strobe | output | 1 | Deglitch strobe, 1 = high |

## Verification
The window is walked over a full period and a wrap for four select pairs. A non-wrapping pair checks the basic rise and fall placement. A wrapping pair separates wrap handling from plain comparison. Equal selects show whether an empty window is produced. Rise at 0 checks the edge at the period boundary itself. Further tests change the selects in mid-period, hold a conflicting select in stand-alone mode, assert start and tick together, and hold the inputs idle. These show whether captures happen only at a period start, whether the start has priority over the tick, and whether the strobe holds between ticks.

// File: rtl/dg_strobe_pkg.sv
// Shared types and the window test for the deglitch strobe generator.
// Assumes a power-of-two interval count given by the index width.
package dg_strobe_pkg;

    localparam int DG_IDX_W = 5;
    localparam int DG_NUM_INTERVALS = 1 << DG_IDX_W;

    typedef logic [DG_IDX_W-1:0] dg_idx_t;

    typedef struct packed {
        dg_idx_t rise;
        dg_idx_t fall;
    } dg_edges_t;

    // Returns 1 when interval idx lies inside the high window [rise, fall),
    // taken modulo the period; an equal rise and fall means no window.
    function automatic logic dg_in_window(dg_idx_t idx, dg_edges_t e);
        logic hit;
        if (e.rise == e.fall) begin
            hit = 1'b0;
        end else if (e.rise < e.fall) begin
            hit = (idx >= e.rise) && (idx < e.fall);
        end else begin
            hit = (idx >= e.rise) || (idx < e.fall);
        end
        return hit;
    endfunction

endpackage

// File: rtl/dg_interval_counter.sv
// Interval counter: tracks which deglitch interval of the sample period is
// current. Assumes period_start wins over interval_tick in the same clock.
// Wraps modulo the interval count when no period start arrives.
module dg_interval_counter
    import dg_strobe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    period_start,
    input  logic    interval_tick,
    output dg_idx_t idx_q,
    output dg_idx_t idx_next
);

    // Next-index selection: restart, advance or hold.
    always_comb begin
        if (period_start) begin
            idx_next = '0;
        end else if (interval_tick) begin
            idx_next = idx_q + dg_idx_t'(1);
        end else begin
            idx_next = idx_q;
        end
    end

    // Index register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_next;
        end
    end

endmodule

// File: rtl/dg_edge_select.sv
// Edge select capture: holds the rise and fall indices in use for the
// current period. New selects, or the stand-alone defaults, are taken only
// at a period start. Resets to an empty window (rise equal to fall).
module dg_edge_select
    import dg_strobe_pkg::*;
#(
    parameter dg_idx_t DEF_RISE = dg_idx_t'(31),
    parameter dg_idx_t DEF_FALL = dg_idx_t'(15)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      period_start,
    input  logic      standalone,
    input  dg_idx_t   rise_sel,
    input  dg_idx_t   fall_sel,
    output dg_edges_t edges_q,
    output dg_edges_t edges_next
);

    dg_edges_t requested;

    // Pick programmed or fixed edge positions.
    always_comb begin
        if (standalone) begin
            requested.rise = DEF_RISE;
            requested.fall = DEF_FALL;
        end else begin
            requested.rise = rise_sel;
            requested.fall = fall_sel;
        end
    end

    // Load the request only at a period start.
    always_comb begin
        edges_next = period_start ? requested : edges_q;
    end

    // Captured edge register; reset gives no window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_q <= '0;
        end else begin
            edges_q <= edges_next;
        end
    end

endmodule

// File: rtl/dg_window_decode.sv
// Window decode: registers the strobe from the next index and the next edge
// pair. The strobe then changes on the same edge as the index, with no
// combinational path to the output.
module dg_window_decode
    import dg_strobe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dg_idx_t   idx_next,
    input  dg_edges_t edges_next,
    output logic      strobe_q
);

    logic strobe_d;

    // Window membership of the coming interval.
    always_comb begin
        strobe_d = dg_in_window(idx_next, edges_next);
    end

    // Output register, low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe_d;
        end
    end

endmodule

// File: rtl/dg_strobe_gen.sv
// Deglitch strobe generator top level. Splits each sample period into
// intervals and drives a strobe high from the start of the rise interval to
// the start of the fall interval, with wrap across the period boundary.
// Assumes period_start and interval_tick are single-clock pulses in clk.
module dg_strobe_gen
    import dg_strobe_pkg::*;
#(
    parameter dg_idx_t DEF_RISE = dg_idx_t'(31),
    parameter dg_idx_t DEF_FALL = dg_idx_t'(15)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                period_start,
    input  logic                interval_tick,
    input  logic [DG_IDX_W-1:0] rise_sel,
    input  logic [DG_IDX_W-1:0] fall_sel,
    input  logic                standalone,
    output logic                strobe
);

    dg_idx_t   idx_q;
    dg_idx_t   idx_next;
    dg_edges_t edges_q;
    dg_edges_t edges_next;

    dg_interval_counter u_counter (
        .clk           (clk),
        .rst_n         (rst_n),
        .period_start  (period_start),
        .interval_tick (interval_tick),
        .idx_q         (idx_q),
        .idx_next      (idx_next)
    );

    dg_edge_select #(
        .DEF_RISE (DEF_RISE),
        .DEF_FALL (DEF_FALL)
    ) u_edges (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .standalone   (standalone),
        .rise_sel     (rise_sel),
        .fall_sel     (fall_sel),
        .edges_q      (edges_q),
        .edges_next   (edges_next)
    );

    dg_window_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_next   (idx_next),
        .edges_next (edges_next),
        .strobe_q   (strobe)
    );

endmodule

// File: rtl/dg_strobe_checker.sv
// Property checker for the deglitch strobe generator, bound to the top level.
module dg_strobe_checker
    import dg_strobe_pkg::*;
#(
    parameter dg_idx_t DEF_RISE = dg_idx_t'(31),
    parameter dg_idx_t DEF_FALL = dg_idx_t'(15)
) (
    input logic      clk,
    input logic      rst_n,
    input logic      period_start,
    input logic      interval_tick,
    input logic      standalone,
    input dg_idx_t   idx_q,
    input dg_edges_t edges_q,
    input logic      strobe
);

    // R2: a period start restarts the index at zero
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> (idx_q == '0));

    // R2 and R10: a lone tick advances the index modulo the period
    assert_tick_advances_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_tick && !period_start) |=> (idx_q == dg_idx_t'($past(idx_q) + dg_idx_t'(1))));

    // R7: captured edges hold between period starts
    assert_edges_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(edges_q));

    // R8: stand-alone capture loads the fixed edge pair
    assert_standalone_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && standalone) |=> (edges_q.rise == DEF_RISE && edges_q.fall == DEF_FALL));

    // R6: an empty window never drives the strobe high
    assert_empty_window_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q.rise == edges_q.fall) |-> !strobe);

    // R9: without a start or a tick the strobe holds
    assert_strobe_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_start && !interval_tick) |=> $stable(strobe));

endmodule

bind dg_strobe_gen dg_strobe_checker #(
    .DEF_RISE (DEF_RISE),
    .DEF_FALL (DEF_FALL)
) u_dg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .period_start  (period_start),
    .interval_tick (interval_tick),
    .standalone    (standalone),
    .idx_q         (idx_q),
    .edges_q       (edges_q),
    .strobe        (strobe)
);

// File: tb/tb_dg_strobe_gen.sv
// Directed bench for the deglitch strobe generator: one task per scenario.
module tb_dg_strobe_gen;

    logic       clk;
    logic       rst_n;
    logic       period_start;
    logic       interval_tick;
    logic [4:0] rise_sel;
    logic [4:0] fall_sel;
    logic       standalone;
    logic       strobe;

    int checks;
    int failures;
    int cycles;
    int cur_idx;

    dg_strobe_gen dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .period_start  (period_start),
        .interval_tick (interval_tick),
        .rise_sel      (rise_sel),
        .fall_sel      (fall_sel),
        .standalone    (standalone),
        .strobe        (strobe)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Expected strobe from the requirement text: [rise, fall) modulo 32.
    function automatic logic expect_hi(int idx, int r, int f);
        if (r == f) return 1'b0;
        if (r < f) return (idx >= r) && (idx < f);
        return (idx >= r) || (idx < f);
    endfunction

    task automatic check(string req, logic actual, logic expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s idx=%0d actual=%0b expected=%0b", req, cur_idx, actual, expected);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) period_start = 1'b1;
        @(negedge clk) period_start = 1'b0;
        cur_idx = 0;
    endtask

    task automatic pulse_tick();
        @(negedge clk) interval_tick = 1'b1;
        @(negedge clk) interval_tick = 1'b0;
        cur_idx = (cur_idx + 1) % 32;
    endtask

    // R1: low after reset, ticks alone do not open a window
    task automatic t_reset();
        check("R1", strobe, 1'b0);
        for (int i = 0; i < 40; i++) begin
            pulse_tick();
            check("R1", strobe, 1'b0);
        end
    endtask

    // R2..R6, R10: walk a full period plus a wrap with one select pair
    task automatic t_window(int r, int f, string req);
        @(negedge clk);
        standalone = 1'b0;
        rise_sel = 5'(r);
        fall_sel = 5'(f);
        pulse_start();
        check(req, strobe, expect_hi(0, r, f));
        for (int i = 0; i < 36; i++) begin
            pulse_tick();
            check(i >= 31 ? "R10" : req, strobe, expect_hi(cur_idx, r, f));
        end
    endtask

    // R7: mid-period select changes wait for the next period start
    task automatic t_midchange();
        rise_sel = 5'd4;
        fall_sel = 5'd8;
        pulse_start();
        pulse_tick();
        pulse_tick();
        rise_sel = 5'd0;
        fall_sel = 5'd1;
        standalone = 1'b1;
        for (int i = 0; i < 10; i++) begin
            pulse_tick();
            check("R7", strobe, expect_hi(cur_idx, 4, 8));
        end
        standalone = 1'b0;
        pulse_start();
        check("R7", strobe, 1'b1);
        pulse_tick();
        check("R7", strobe, 1'b0);
    endtask

    // R8: stand-alone overrides the selects with 31 and 15
    task automatic t_standalone();
        standalone = 1'b1;
        rise_sel = 5'd3;
        fall_sel = 5'd5;
        pulse_start();
        check("R8", strobe, 1'b1);
        for (int i = 0; i < 33; i++) begin
            pulse_tick();
            check("R8", strobe, expect_hi(cur_idx, 31, 15));
        end
        standalone = 1'b0;
    endtask

    // R2: period start has priority over a tick in the same clock
    task automatic t_priority();
        rise_sel = 5'd0;
        fall_sel = 5'd1;
        pulse_start();
        for (int i = 0; i < 5; i++) pulse_tick();
        check("R2", strobe, 1'b0);
        @(negedge clk) begin
            period_start = 1'b1;
            interval_tick = 1'b1;
        end
        @(negedge clk) begin
            period_start = 1'b0;
            interval_tick = 1'b0;
        end
        cur_idx = 0;
        check("R2", strobe, 1'b1);
    endtask

    // R9: strobe holds while no start or tick arrives
    task automatic t_idle();
        rise_sel = 5'd0;
        fall_sel = 5'd3;
        pulse_start();
        pulse_tick();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R9", strobe, 1'b1);
        end
        pulse_tick();
        pulse_tick();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R9", strobe, 1'b0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        checks = 0;
        failures = 0;
        cur_idx = 0;
        rst_n = 1'b0;
        period_start = 1'b0;
        interval_tick = 1'b0;
        rise_sel = 5'd0;
        fall_sel = 5'd0;
        standalone = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window(5, 12, "R3");
        t_window(20, 6, "R5");
        t_window(9, 9, "R6");
        t_window(0, 31, "R4");
        t_midchange();
        t_standalone();
        t_priority();
        t_idle();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule